// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDR, DDR, LPDDR or DDR2 SDRAM from reset to a usable state without software. A single-cycle `start` pulse launches a fixed list of steps on one command phase. Each step either raises the clock enable or issues one command with its address and bank. A programmed number of idle cycles follows each step. When the last wait has run out, `init_done` rises, and it stays high until reset.

The memory type, CAS latency and phase count are elaboration parameters. They select whether the extended mode register step is present and which bank it uses. They also set the burst length and the mode register word. The mode register is loaded twice: the first load has the DLL reset bit set and the second has it clear. The controller that owns the memory afterwards waits for `init_done` before it sends traffic.

Parameter `MEM_KIND` encodes the memory type: 0 = SDR, 1 = DDR, 2 = LPDDR, 3 = DDR2.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset and until `start` is sampled, `mem_cke` is 0 and `init_done` is 0. The command pins `{cs_n,ras_n,cas_n,we_n}` are all 1 (the NOP encoding), and address and bank are 0.
- R2: The cycle after the edge that samples `start` still shows the idle outputs. The cycle after that shows the first step, in which `mem_cke` rises and no command is issued.
- R3: The steps come in this order: clock enable, precharge all, extended mode load (absent for SDR), mode load with DLL reset, precharge all, auto refresh, final mode load.
- R4: After each step come exactly this many NOP cycles: 2000 after clock enable, 0 after each precharge all and after the extended mode load, 200 after each mode load, and 4 after auto refresh. During a NOP cycle, address and bank are 0.
- R5: Every command is driven for exactly one cycle with active-low pins. Auto refresh is `{cs_n,ras_n,cas_n,we_n}` = 0001, precharge all is 0010 and a mode load is 0000.
- R6: Precharge all drives address 0x400 (bit 10 set) on bank 0. Auto refresh drives address 0 on bank 0.
- R7: The extended mode load drives address 0. Its bank is 1 for DDR and DDR2 and 2 for LPDDR.
- R8: The mode word is log2(burst length) + (CAS latency << 4). Burst length is the phase count for SDR and twice the phase count for the other types. The first mode load adds bit 8 (DLL reset); the final load leaves bit 8 clear. Both loads use bank 0.
- R9: Once `mem_cke` has risen it stays high.
- R10: `init_done` rises in the cycle after the final 200-cycle wait and stays high until reset. While it is high, the command pins show NOP.
- R11: A `start` pulse while the sequence is running, or after `init_done`, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle pulse that launches the sequence |
| init_done | output | 1 | High once the whole sequence has completed |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_bank | output | BANK_W | Bank address |

## Verification
The step list depends on parameters: the extended mode step, its bank, and the mode word all change with memory type and phase count. A single instance therefore cannot reach every variant. The bench builds four instances side by side, one per memory type, each with its own CAS latency and phase count, so that four distinct mode words appear. Each instance is compared on every cycle against an expected trace built from the requirements. The hardest case is a stray `start` in the middle of the long clock-enable wait. The bench injects one there, and another after completion, and the trace comparison shows that no cycle shifted.

// File: rtl/sdram_init_pkg.sv
// Shared types and helper functions for the SDRAM power-up sequencer.
// Assumes the phase count is a power of two.
package sdram_init_pkg;

    typedef enum logic [1:0] {
        MEM_SDR   = 2'd0,
        MEM_DDR   = 2'd1,
        MEM_LPDDR = 2'd2,
        MEM_DDR2  = 2'd3
    } mem_kind_e;

    typedef enum logic [2:0] {
        STEP_CKE,
        STEP_PRE_ALL,
        STEP_EMR,
        STEP_MRS_DLL,
        STEP_REFRESH,
        STEP_MRS
    } step_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PIN_NOP     = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pin_cmd_t PIN_PRE_ALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam pin_cmd_t PIN_MODE    = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam pin_cmd_t PIN_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    localparam int DLL_RESET_BIT = 8;
    localparam int PRE_ALL_ADDR  = 1024;

    function automatic int burst_len(mem_kind_e kind, int phases);
        return (kind == MEM_SDR) ? phases : 2 * phases;
    endfunction

    function automatic int mode_word(mem_kind_e kind, int cas_lat, int phases);
        return $clog2(burst_len(kind, phases)) + (cas_lat << 4);
    endfunction

endpackage

// File: rtl/sdram_init_step_table.sv
// Step table: maps a step index to the step kind, pin command, address,
// bank and post-step wait. Purely combinational. Assumes that indices past
// the last step are never acted on.
module sdram_init_step_table
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e MEM_KIND = MEM_DDR,
    parameter int CAS_LAT  = 3,
    parameter int PHASES   = 2,
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 11,
    parameter int WAIT_CKE = 2000,
    parameter int WAIT_MRS = 200,
    parameter int WAIT_REF = 4
) (
    input  logic [IDX_W-1:0]  step_idx,
    output step_kind_e        step_kind,
    output pin_cmd_t          step_cmd,
    output logic [ADDR_W-1:0] step_addr,
    output logic [BANK_W-1:0] step_bank,
    output logic [CNT_W-1:0]  step_wait
);

    localparam bit HAS_EMR  = (MEM_KIND != MEM_SDR);
    localparam int EMR_BANK = (MEM_KIND == MEM_LPDDR) ? 2 : 1;
    localparam int MODE     = mode_word(MEM_KIND, CAS_LAT, PHASES);

    logic [IDX_W-1:0] slot;

    // Skip the extended-mode slot when the memory type has none.
    always_comb begin
        if (!HAS_EMR && step_idx >= IDX_W'(2))
            slot = step_idx + IDX_W'(1);
        else
            slot = step_idx;
    end

    // Slot to step kind, in the fixed power-up order.
    always_comb begin
        case (slot)
            IDX_W'(0): step_kind = STEP_CKE;
            IDX_W'(1): step_kind = STEP_PRE_ALL;
            IDX_W'(2): step_kind = STEP_EMR;
            IDX_W'(3): step_kind = STEP_MRS_DLL;
            IDX_W'(4): step_kind = STEP_PRE_ALL;
            IDX_W'(5): step_kind = STEP_REFRESH;
            default:   step_kind = STEP_MRS;
        endcase
    end

    // Step kind to pins, address, bank and wait count.
    always_comb begin
        step_cmd  = PIN_NOP;
        step_addr = '0;
        step_bank = '0;
        step_wait = '0;
        case (step_kind)
            STEP_CKE: begin
                step_wait = CNT_W'(WAIT_CKE);
            end
            STEP_PRE_ALL: begin
                step_cmd  = PIN_PRE_ALL;
                step_addr = ADDR_W'(PRE_ALL_ADDR);
            end
            STEP_EMR: begin
                step_cmd  = PIN_MODE;
                step_bank = BANK_W'(EMR_BANK);
            end
            STEP_MRS_DLL: begin
                step_cmd  = PIN_MODE;
                step_addr = ADDR_W'(MODE + (1 << DLL_RESET_BIT));
                step_wait = CNT_W'(WAIT_MRS);
            end
            STEP_REFRESH: begin
                step_cmd  = PIN_REFRESH;
                step_wait = CNT_W'(WAIT_REF);
            end
            default: begin
                step_cmd  = PIN_MODE;
                step_addr = ADDR_W'(MODE);
                step_wait = CNT_W'(WAIT_MRS);
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_wait_timer.sv
// Down-counting wait timer. Loading a value N yields N further cycles in
// which expired is low. Assumes a load only arrives once the count is at zero.
module sdram_init_wait_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    // R4
    load_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up sequencer top. It steps through the step table and drives
// registered memory pins. Each step lasts one cycle and is followed by its
// wait of NOP cycles. Assumes start is a single-cycle pulse.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter mem_kind_e MEM_KIND = MEM_DDR,
    parameter int CAS_LAT  = 3,
    parameter int PHASES   = 2,
    parameter int ADDR_W   = 13,
    parameter int BANK_W   = 2,
    parameter int WAIT_CKE = 2000,
    parameter int WAIT_MRS = 200,
    parameter int WAIT_REF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              init_done,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank
);

    localparam int NUM_STEPS = (MEM_KIND == MEM_SDR) ? 6 : 7;
    localparam int IDX_W     = $clog2(NUM_STEPS + 1);
    localparam int MAX_WAIT  = (WAIT_CKE > WAIT_MRS)
                             ? ((WAIT_CKE > WAIT_REF) ? WAIT_CKE : WAIT_REF)
                             : ((WAIT_MRS > WAIT_REF) ? WAIT_MRS : WAIT_REF);
    localparam int CNT_W     = $clog2(MAX_WAIT + 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} seq_state_e;

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              cke_q;
    logic              done_q;
    pin_cmd_t          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BANK_W-1:0] bank_q;

    step_kind_e        step_kind;
    pin_cmd_t          step_cmd;
    logic [ADDR_W-1:0] step_addr;
    logic [BANK_W-1:0] step_bank;
    logic [CNT_W-1:0]  step_wait;
    logic              timer_expired;
    logic              timer_load;
    logic              all_issued;

    sdram_init_step_table #(
        .MEM_KIND (MEM_KIND),
        .CAS_LAT  (CAS_LAT),
        .PHASES   (PHASES),
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W),
        .WAIT_CKE (WAIT_CKE),
        .WAIT_MRS (WAIT_MRS),
        .WAIT_REF (WAIT_REF)
    ) u_table (
        .step_idx  (idx_q),
        .step_kind (step_kind),
        .step_cmd  (step_cmd),
        .step_addr (step_addr),
        .step_bank (step_bank),
        .step_wait (step_wait)
    );

    sdram_init_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (step_wait),
        .expired  (timer_expired)
    );

    // Completion flag and timer reload whenever a step is issued.
    assign all_issued = (idx_q == IDX_W'(NUM_STEPS));
    assign timer_load = (state_q == S_RUN) && timer_expired && !all_issued;

    // Sequence control and registered pin drive (NOP unless a step issues).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            cke_q   <= 1'b0;
            done_q  <= 1'b0;
            cmd_q   <= PIN_NOP;
            addr_q  <= '0;
            bank_q  <= '0;
        end else begin
            cmd_q  <= PIN_NOP;
            addr_q <= '0;
            bank_q <= '0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_q <= S_RUN;
                        idx_q   <= '0;
                    end
                end
                S_RUN: begin
                    if (timer_expired) begin
                        if (all_issued) begin
                            state_q <= S_DONE;
                            done_q  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                            if (step_kind == STEP_CKE) begin
                                cke_q <= 1'b1;
                            end else begin
                                cmd_q  <= step_cmd;
                                addr_q <= step_addr;
                                bank_q <= step_bank;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign init_done = done_q;
    assign mem_cke   = cke_q;
    assign mem_cs_n  = cmd_q.cs_n;
    assign mem_ras_n = cmd_q.ras_n;
    assign mem_cas_n = cmd_q.cas_n;
    assign mem_we_n  = cmd_q.we_n;
    assign mem_addr  = addr_q;
    assign mem_bank  = bank_q;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> (cmd_q == PIN_NOP && !done_q));

    // R9
    cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_q |=> cke_q);

    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (cke_q && cmd_q == PIN_NOP));

    // R10
    done_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(timer_expired));

    // R4
    nop_zero_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == PIN_NOP) |-> (addr_q == '0 && bank_q == '0));

    // R5
    cmd_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q != PIN_NOP) |-> cke_q);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
    import sdram_init_pkg::*;

    localparam int AW = 13;
    localparam int BW = 2;
    localparam int VW = 6 + BW + AW;
    localparam int MAX_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    function automatic string tag_name(int t);
        case (t)
            1:  return "R1";
            2:  return "R2";
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            7:  return "R7";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [VW-1:0] pk(logic d, logic c, logic [3:0] pins,
                                         logic [BW-1:0] bk, logic [AW-1:0] ad);
        return {d, c, pins, bk, ad};
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_type
        localparam int CL = (g == 0) ? 2 : ((g == 3) ? 4 : 3);
        localparam int PH = (g == 2) ? 1 : ((g == 3) ? 4 : 2);
        localparam int BL = (g == 0) ? PH : 2 * PH;
        localparam int MW = $clog2(BL) + CL * 16;

        logic st;
        logic done_o, cke, cs_n, ras_n, cas_n, we_n;
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        int n_chk = 0;
        int n_err = 0;
        bit fin = 1'b0;
        logic [VW-1:0] exp_q[$];
        int tag_q[$];
        logic [VW-1:0] cmd_exp[$];
        logic [VW-1:0] cmd_obs[$];

        sdram_init_seq #(
            .MEM_KIND (mem_kind_e'(g)),
            .CAS_LAT  (CL),
            .PHASES   (PH),
            .ADDR_W   (AW),
            .BANK_W   (BW)
        ) u_dut (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (st),
            .init_done (done_o),
            .mem_cke   (cke),
            .mem_cs_n  (cs_n),
            .mem_ras_n (ras_n),
            .mem_cas_n (cas_n),
            .mem_we_n  (we_n),
            .mem_addr  (a),
            .mem_bank  (b)
        );

        task automatic add_step(logic [3:0] pins, int bk, int ad, int wt, int tag);
            logic [VW-1:0] v;
            v = pk(1'b0, 1'b1, pins, BW'(bk), AW'(ad));
            exp_q.push_back(v);
            tag_q.push_back(tag);
            if (pins != 4'hF) cmd_exp.push_back(v);
            for (int k = 0; k < wt; k++) begin
                exp_q.push_back(pk(1'b0, 1'b1, 4'hF, '0, '0));
                tag_q.push_back(4);
            end
        endtask

        task automatic check(logic [VW-1:0] e, int tag);
            logic [VW-1:0] act;
            act = pk(done_o, cke, {cs_n, ras_n, cas_n, we_n}, b, a);
            n_chk++;
            if (act !== e) begin
                n_err++;
                $display("FAIL %s type %0d: actual %h expected %h", tag_name(tag), g, act, e);
            end
        endtask

        initial begin
            logic [VW-1:0] idle_v, done_v, e;
            int t, i;
            bit cke_seen, cke_fell;
            st = 1'b0;
            idle_v = pk(1'b0, 1'b0, 4'hF, '0, '0);
            done_v = pk(1'b1, 1'b1, 4'hF, '0, '0);
            // R2 clock enable, R6 precharge, R7 ext mode, R8 mode loads, R5 refresh, R4 waits
            add_step(4'hF, 0, 0, 2000, 2);
            add_step(4'b0010, 0, 1024, 0, 6);
            if (g != 0) add_step(4'b0000, (g == 2) ? 2 : 1, 0, 0, 7);
            add_step(4'b0000, 0, MW + 256, 200, 8);
            add_step(4'b0010, 0, 1024, 0, 6);
            add_step(4'b0001, 0, 0, 4, 5);
            add_step(4'b0000, 0, MW, 200, 8);
            exp_q.push_back(done_v);
            tag_q.push_back(10);

            wait (rst_n === 1'b1);
            // R1: idle outputs before start
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(idle_v, 1);
            end
            st = 1'b1;
            @(negedge clk);
            st = 1'b0;
            check(idle_v, 2);   // R2: one cycle of latency
            i = 0;
            cke_seen = 1'b0;
            cke_fell = 1'b0;
            while (exp_q.size() > 0) begin
                @(negedge clk);
                st = (i == 150);   // R11: stray start during the clock-enable wait
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(e, t);
                if (cke) cke_seen = 1'b1;
                else if (cke_seen) cke_fell = 1'b1;
                if ({cs_n, ras_n, cas_n, we_n} != 4'hF)
                    cmd_obs.push_back(pk(done_o, cke, {cs_n, ras_n, cas_n, we_n}, b, a));
                i++;
            end
            // R10 and R11: done holds, a start after completion does nothing
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                st = (k == 3);
                check(done_v, (k > 3) ? 11 : 10);
                if (!cke) cke_fell = 1'b1;
            end
            st = 1'b0;
            // R3: full command order
            n_chk++;
            if (cmd_obs.size() != cmd_exp.size()) begin
                n_err++;
                $display("FAIL R3 type %0d: actual %0d commands expected %0d",
                         g, cmd_obs.size(), cmd_exp.size());
            end else begin
                for (int k = 0; k < cmd_exp.size(); k++) begin
                    if (cmd_obs[k] !== cmd_exp[k]) begin
                        n_err++;
                        $display("FAIL R3 type %0d step %0d: actual %h expected %h",
                                 g, k, cmd_obs[k], cmd_exp[k]);
                        break;
                    end
                end
            end
            // R9: clock enable never fell
            n_chk++;
            if (cke_fell || !cke_seen) begin
                n_err++;
                $display("FAIL R9 type %0d: actual fell=%0d seen=%0d expected fell=0 seen=1",
                         g, cke_fell, cke_seen);
            end
            fin = 1'b1;
        end
    end

    initial begin
        int cyc;
        int total_chk;
        int total_err;
        bit timed_out;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        timed_out = 1'b0;
        while (!(g_type[0].fin && g_type[1].fin && g_type[2].fin && g_type[3].fin)) begin
            @(posedge clk);
            cyc++;
            if (cyc >= MAX_CYCLES) begin
                timed_out = 1'b1;
                break;
            end
        end
        total_chk = g_type[0].n_chk + g_type[1].n_chk + g_type[2].n_chk + g_type[3].n_chk;
        total_err = g_type[0].n_err + g_type[1].n_err + g_type[2].n_err + g_type[3].n_err;
        if (timed_out) begin
            total_chk++;
            total_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        $display("Result: errors=%0d of %0d checks", total_err, total_chk);
        $finish;
    end

endmodule